// File: doc/BRIEF.md
# Dual-Lane Two-Bit Framed Byte Transmitter

This block is the master side of a point-to-point serial link that shares its clock with the far end. Each lane takes whole bytes through a valid/ready handshake and sends each one as four 2-bit symbols on a narrow data path. Alongside the data it drives a byte-start strobe and a superframe-start strobe. Two lanes with identical logic run side by side and do not interact. Lane 0 carries the fast flow and lane 1 carries the interleaved flow.

Each lane changes its outputs on the rising clock edge, so the far end can capture them on the falling edge. A matching receiver module, `pairlink_rx`, captures on the falling edge and rebuilds bytes and frame marks. It is used for loopback checking.

Back-pressure rules for the byte input:
- A byte is accepted on a rising edge where both `in_valid` and `in_ready` of its lane are high.
- While `in_ready` is low, the producer holds `in_valid`, `in_data` and `in_sof` unchanged.
- `in_ready` rises on the last symbol of the current byte, so a held byte follows with no idle cycle.

Top module: `pairlink_dual_tx`

## Requirements
- R1: Every accepted byte occupies exactly four consecutive clock cycles (beats) on its lane, with 2 bits sent per beat.
- R2: Bits go most significant first. On beat k (k = 0..3), `link_data[2*lane+1]` carries byte bit 7-2k and `link_data[2*lane]` carries byte bit 6-2k. Lane 1 therefore uses bits 3:2 of `link_data` and lane 0 uses bits 1:0.
- R3: `link_valid[lane]` is high on beat 0 of each byte and low on beats 1 to 3. When the lane has no byte to send, `link_valid` is low and that lane's data bits are 0.
- R4: `link_frame[lane]` is high only on beat 0 of a byte that was accepted with `in_sof` high. It is low at all other times.
- R5: `in_ready[lane]` is high exactly when the lane is idle or is sending beat 3, so consecutive bytes are sent with no gap.
- R6: Beat 0 of an accepted byte appears on the link outputs in the cycle right after the accepting edge.
- R7: A byte offered while `in_ready` is low is not lost and does not disturb the byte in flight. It is sent in full, in order, once accepted.
- R8: The two lanes are independent: traffic, or its absence, on one lane never changes the other lane's outputs.
- R9: While `rst_n` (active-low, synchronous) is low and right after it is released, `in_ready` is high, and `link_valid`, `link_frame` and `link_data` are all 0.
- R10: The receiver captures the link on the falling edge and rebuilds each byte and its frame mark. A transmit-to-receive loopback returns exactly the sequence of bytes and superframe flags that were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common link clock; outputs change on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | LANES | Per-lane byte offer |
| in_ready | output | LANES | Per-lane byte acceptance |
| in_data | input | LANES*BYTE_W | Per-lane byte; lane n uses bits [8n+7:8n] |
| in_sof | input | LANES | Per-lane flag: this byte starts a superframe |
| link_data | output | LANES*SYM_W | Per-lane 2-bit symbol; lane n uses bits [2n+1:2n] |
| link_valid | output | LANES | Per-lane byte-start strobe |
| link_frame | output | LANES | Per-lane superframe-start strobe |

## Verification
The bench checks the wire mapping of single bytes beat by beat. It uses patterns whose odd and even bits differ, such as 0xAA and 0x5A. A design that swapped the two wires, or sent the byte LSB first, fails on the first symbol. It streams held bytes back to back and checks that `link_valid` recurs exactly every four cycles. A ready signal raised a cycle late would insert an idle beat, and one raised a cycle early would drop the end of a byte. It sets the superframe flag only on selected bytes, which catches a frame strobe that lingers past beat 0 or carries over to the next byte. It drives one lane while the other stays idle and drives both lanes together with different data, which exposes any crossed lane index. A falling-edge loopback then confirms the whole sequence end to end.

// File: rtl/pairlink_pkg.sv
package pairlink_pkg;
  localparam int unsigned PL_BYTE_W = 8;
  localparam int unsigned PL_SYM_W  = 2;

  typedef struct packed {
    logic                frame;
    logic                strobe;
    logic [PL_SYM_W-1:0] sym;
  } pl_beat_t;

  localparam pl_beat_t PL_IDLE_BEAT = '{frame: 1'b0, strobe: 1'b0, sym: '0};
endpackage

// File: rtl/pairlink_tx.sv
module pairlink_tx #(
  parameter int unsigned BYTE_W = pairlink_pkg::PL_BYTE_W,
  parameter int unsigned SYM_W  = pairlink_pkg::PL_SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [BYTE_W-1:0] up_data,
  input  logic              up_sof,
  output logic [SYM_W-1:0]  ln_sym,
  output logic              ln_strobe,
  output logic              ln_frame
);
  import pairlink_pkg::*;

  localparam int unsigned BEATS = BYTE_W / SYM_W;
  localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic              busy_q;
  logic [CNT_W-1:0]  beat_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              sof_q;
  logic              take;
  pl_beat_t          beat_out;

  assign up_ready = !busy_q || (beat_q == LAST_BEAT);
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      beat_q  <= '0;
      shreg_q <= '0;
      sof_q   <= 1'b0;
    end else if (take) begin
      busy_q  <= 1'b1;
      beat_q  <= '0;
      shreg_q <= up_data;
      sof_q   <= up_sof;
    end else if (busy_q) begin
      if (beat_q == LAST_BEAT) begin
        busy_q <= 1'b0;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
      shreg_q <= {shreg_q[BYTE_W-SYM_W-1:0], {SYM_W{1'b0}}};
    end
  end

  always_comb begin
    beat_out = PL_IDLE_BEAT;
    if (busy_q) begin
      beat_out.sym    = shreg_q[BYTE_W-1 -: SYM_W];
      beat_out.strobe = (beat_q == '0);
      beat_out.frame  = (beat_q == '0) && sof_q;
    end
  end

  assign ln_sym    = beat_out.sym;
  assign ln_strobe = beat_out.strobe;
  assign ln_frame  = beat_out.frame;

  // R6
  start_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ln_strobe);
  // R2
  first_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ln_sym == $past(up_data[BYTE_W-1 -: SYM_W])));
  // R4
  frame_follows_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ln_frame == $past(up_sof)));
  // R1
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ln_strobe |=> !ln_strobe ##1 !ln_strobe ##1 !ln_strobe);
  // R5
  ready_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ln_strobe |=> ##2 up_ready);
  // R4
  frame_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ln_frame |-> ln_strobe);
endmodule

// File: rtl/pairlink_rx.sv
module pairlink_rx #(
  parameter int unsigned BYTE_W = pairlink_pkg::PL_BYTE_W,
  parameter int unsigned SYM_W  = pairlink_pkg::PL_SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SYM_W-1:0]  ln_sym,
  input  logic              ln_strobe,
  input  logic              ln_frame,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_sof
);
  localparam int unsigned BEATS = BYTE_W / SYM_W;
  localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic [BYTE_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              frm_q;

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      frm_q    <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_sof   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (ln_strobe) begin
        acc_q <= BYTE_W'(ln_sym);
        cnt_q <= CNT_W'(1);
        frm_q <= ln_frame;
      end else if (cnt_q != '0) begin
        acc_q <= {acc_q[BYTE_W-SYM_W-1:0], ln_sym};
        if (cnt_q == LAST_BEAT) begin
          cnt_q    <= '0;
          rx_valid <= 1'b1;
          rx_data  <= {acc_q[BYTE_W-SYM_W-1:0], ln_sym};
          rx_sof   <= frm_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R10
  rx_pulse_chk: assert property (@(negedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/pairlink_dual_tx.sv
module pairlink_dual_tx #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned BYTE_W = pairlink_pkg::PL_BYTE_W,
  parameter int unsigned SYM_W  = pairlink_pkg::PL_SYM_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        in_valid,
  output logic [LANES-1:0]        in_ready,
  input  logic [LANES*BYTE_W-1:0] in_data,
  input  logic [LANES-1:0]        in_sof,
  output logic [LANES*SYM_W-1:0]  link_data,
  output logic [LANES-1:0]        link_valid,
  output logic [LANES-1:0]        link_frame
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pairlink_tx #(.BYTE_W(BYTE_W), .SYM_W(SYM_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .up_valid  (in_valid[g]),
      .up_ready  (in_ready[g]),
      .up_data   (in_data[g*BYTE_W +: BYTE_W]),
      .up_sof    (in_sof[g]),
      .ln_sym    (link_data[g*SYM_W +: SYM_W]),
      .ln_strobe (link_valid[g]),
      .ln_frame  (link_frame[g])
    );
  end

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(in_valid[0] && in_ready[0]) && $past(in_ready[0]) && !link_valid[0])
      |-> (link_data[SYM_W-1:0] == '0));
endmodule

// File: tb/pairlink_dual_tx_bench.sv
module pairlink_dual_tx_bench;
  localparam int LANES = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  in_valid = '0, in_ready, in_sof = '0;
  logic [15:0] in_data = '0;
  logic [3:0]  link_data;
  logic [1:0]  link_valid, link_frame;
  logic [1:0]  rx_valid, rx_sof;
  logic [7:0]  rx_data [2];
  int checks = 0, errors = 0;
  logic [8:0] got_q [2][$];

  always #4 clk = ~clk;

  pairlink_dual_tx u_pairlink_dual_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .link_data(link_data),
    .link_valid(link_valid), .link_frame(link_frame));

  for (genvar g = 0; g < LANES; g++) begin : g_rx
    pairlink_rx u_rx (
      .clk(clk), .rst_n(rst_n), .ln_sym(link_data[2*g +: 2]),
      .ln_strobe(link_valid[g]), .ln_frame(link_frame[g]),
      .rx_valid(rx_valid[g]), .rx_data(rx_data[g]), .rx_sof(rx_sof[g]));
  end

  always @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (rx_valid[l]) got_q[l].push_back({rx_sof[l], rx_data[l]});
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // holds the offer until ready, returns 1ns after the accepting edge
  task automatic send(int lane, logic [7:0] d, logic sof);
    in_valid[lane] = 1'b1; in_data[lane*8 +: 8] = d; in_sof[lane] = sof;
    while (!in_ready[lane]) step();
    step();
    in_valid[lane] = 1'b0; in_sof[lane] = 1'b0;
  endtask

  task automatic check_beats(int lane, logic [7:0] d, logic sof, string req);
    for (int k = 0; k < 4; k++) begin
      chk({req, " sym"}, 16'(link_data[2*lane +: 2]), 16'({d[7-2*k], d[6-2*k]}));
      chk({req, " valid"}, 16'(link_valid[lane]), 16'(k == 0));
      chk({req, " frame"}, 16'(link_frame[lane]), 16'((k == 0) && sof));
      chk({req, " ready"}, 16'(in_ready[lane]), 16'(k == 3));
      step();
    end
  endtask

  task automatic t_reset();
    step();
    chk("R9 ready", 16'(in_ready), 16'h3);
    chk("R9 outs", {link_frame, link_valid, link_data}, 16'h0);
    rst_n = 1'b1; step();
    chk("R9 after release", {6'd0, in_ready, link_frame, link_valid, link_data}, 16'h300);
  endtask

  task automatic t_single();
    send(0, 8'hAA, 1'b0);
    check_beats(0, 8'hAA, 1'b0, "R1 R2 R6 lane0 AA");
    chk("R3 idle", {link_valid, link_data[1:0]}, 16'h0);
    send(0, 8'h5A, 1'b1);
    check_beats(0, 8'h5A, 1'b1, "R2 R4 lane0 5A");
    chk("R4 frame cleared", 16'(link_frame), 16'h0);
    chk("R3 idle again", 16'({link_valid[0], link_data[1:0]}), 16'h0);
  endtask

  task automatic t_b2b();
    logic [7:0] seq [4] = '{8'h81, 8'h3C, 8'hE7, 8'h12};
    got_q[1].delete();
    fork
      begin
        for (int i = 0; i < 4; i++) send(1, seq[i], i == 0);
      end
      begin
        for (int c = 0; c < 16; c++) begin
          @(posedge clk); #2;
          chk("R5 R1 no gap valid", 16'(link_valid[1]), 16'((c % 4) == 0));
          chk("R3 other lane quiet R8", {link_valid[0], link_frame[0], link_data[1:0]}, 16'h0);
        end
      end
    join
    repeat (4) step();
    chk("R10 b2b count", 16'(got_q[1].size()), 16'd4);
    for (int i = 0; i < 4 && i < got_q[1].size(); i++)
      chk("R10 R7 b2b byte", 16'(got_q[1][i]), 16'({i == 0, seq[i]}));
  endtask

  task automatic t_backpressure();
    send(0, 8'hC3, 1'b0);
    in_valid[0] = 1'b1; in_data[7:0] = 8'h96; in_sof[0] = 1'b1;
    chk("R7 ready low busy", 16'(in_ready[0]), 16'h0);
    check_beats(0, 8'hC3, 1'b0, "R7 in-flight intact");
    in_valid[0] = 1'b0; in_sof[0] = 1'b0;
    check_beats(0, 8'h96, 1'b1, "R7 held byte sent");
  endtask

  task automatic t_lanes();
    got_q[0].delete(); got_q[1].delete();
    fork
      send(0, 8'h0F, 1'b1);
      send(1, 8'hF0, 1'b0);
    join
    for (int k = 0; k < 4; k++) begin
      chk("R8 lane0 sym", 16'(link_data[1:0]), 16'({1'b0, 1'b0} | ((k >= 2) ? 2'b11 : 2'b00)));
      chk("R8 lane1 sym", 16'(link_data[3:2]), 16'((k < 2) ? 2'b11 : 2'b00));
      chk("R8 strobes", {link_frame, link_valid}, (k == 0) ? 16'b0111 : 16'h0);
      step();
    end
    step();
    chk("R10 lane0 loop", (got_q[0].size() == 1) ? 16'(got_q[0][0]) : 16'hFFFF, 16'h10F);
    chk("R10 lane1 loop", (got_q[1].size() == 1) ? 16'(got_q[1][0]) : 16'hFFFF, 16'h0F0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single();
        t_b2b();
        t_backpressure();
        t_lanes();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule